// File: doc/BRIEF.md
# Sequential Hit-Vector Address Extractor

This block takes a wide match vector produced by a content-addressable lookup stage and turns it into a stream of bit indices. Each index goes out on its own clock cycle, so a downstream RAM can use it as a write address for one write after another. The vector may have several bits set. The block keeps a working copy of the vector. Every cycle a priority encoder picks the lowest set bit of that copy, and the block issues its index and clears the bit. The next cycle then finds the next bit. The run stops once the copy is empty.

The host presents a vector together with a one-cycle load strobe while the block is idle. From the next cycle on the block raises busy and a valid flag and issues one index per cycle, lowest index first. In the cycle after the last index it pulses done. An empty vector issues nothing and pulses done straight away. A strobe that arrives while a run is in progress is dropped. A strobe that arrives in the done cycle is taken, so runs can follow each other back to back.

Top module: `hit_drain`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o, addr_vld_o and done_o are low and addr_o is 0.
- R2: After a load of a vector with N set bits (1 to 4), addr_vld_o is high for exactly N consecutive cycles, starting in the cycle after the load edge. The addresses issued in those cycles are exactly the set-bit positions, where bit i of vec_i gives address i.
- R3: Within one run the addresses come out in strictly ascending order, so the lowest set bit is issued first.
- R4: A loaded vector holds at most 4 set bits, so no run issues more than 4 addresses.
- R5: busy_o is high in exactly the cycles in which addr_vld_o is high.
- R6: done_o is high for one cycle, in the cycle right after the last address. busy_o and addr_vld_o are low in that cycle. done_o is low again in the following cycle unless a new empty vector was loaded.
- R7: Loading an all-zero vector makes done_o high in the next cycle. No address is issued and busy_o stays low.
- R8: A load strobe that arrives while busy_o is high is ignored. The run in progress issues the same addresses it would have issued without the strobe, and no extra run follows it.
- R9: addr_o is 0 in every cycle where addr_vld_o is low.
- R10: A load strobe in the done_o cycle is accepted. The first address of the new vector appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load strobe; taken only while busy_o is low |
| vec_i | input | 32 | Hit vector to drain, sampled with load_i |
| addr_o | output | 5 | Index of the bit issued this cycle |
| addr_vld_o | output | 1 | addr_o carries an issued index |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after a run ends |

## Verification
The checker assumes that any vector presented with an accepted load strobe has at most four set bits. Under that assumption it can bound the per-run address count and treat the ordering and pairing of busy and valid as invariants. The stimulus meets this by building every vector from one to four chosen positions: all single bits, all pairs, evenly spaced triples and quads, and the empty vector. The one vector with more bits set is driven only while a run is active, where it must be dropped, so the assumption is never exercised with it.

// File: rtl/hd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the hit-vector drain block.
// Assumes nothing beyond the standard language.
package hd_pkg;
    // Controller states: waiting for a load, or draining set bits.
    typedef enum logic [0:0] {
        HD_IDLE  = 1'b0,
        HD_DRAIN = 1'b1
    } hd_state_e;
endpackage

// File: rtl/hd_prio_enc.sv
`timescale 1ns/1ps
// Module: hd_prio_enc
// Finds the lowest-numbered set bit of its input and gives its index.
// Assumes VEC_W >= 2. Gives index 0 and found=0 for an empty input.
module hd_prio_enc #(
    parameter int VEC_W = 32,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // Scan from the top down so that the lowest set bit is written last and wins.
    always_comb begin
        idx   = '0;
        found = |vec;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/hd_work_reg.sv
`timescale 1ns/1ps
// Module: hd_work_reg
// Holds the working copy of the hit vector. On a load it takes the new
// vector. On a step it clears the bit whose index is sel_idx.
// Assumes load_take and step are never high together.
module hd_work_reg #(
    parameter int VEC_W = 32,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_take,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             step,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [VEC_W-1:0] work_q,
    output logic             rest_zero
);
    logic [VEC_W-1:0] clr_mask;
    logic [VEC_W-1:0] rest;

    // One decoder line per bit: it selects the bit issued this cycle.
    for (genvar g = 0; g < VEC_W; g++) begin : g_mask
        assign clr_mask[g] = (sel_idx == IDX_W'(g));
    end

    // The copy left over once this cycle's bit is removed.
    always_comb begin
        rest      = work_q & ~clr_mask;
        rest_zero = (rest == '0);
    end

    // Register the working copy: load, clear one bit, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (load_take) begin
            work_q <= vec_i;
        end else if (step) begin
            work_q <= rest;
        end
    end
endmodule

// File: rtl/hd_ctrl.sv
`timescale 1ns/1ps
// Module: hd_ctrl
// Sequences the run. It accepts a load only while idle, steps the working
// copy while draining, and raises a one-cycle done pulse at the end.
// Assumes rest_zero refers to the working copy after this cycle's clear.
module hd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic vec_zero,
    input  logic rest_zero,
    output logic load_take,
    output logic step,
    output logic busy,
    output logic done
);
    import hd_pkg::*;

    hd_state_e state_q, state_d;
    logic      done_d;

    // Derive the handshake strobes from the state.
    always_comb begin
        load_take = load_i && (state_q == HD_IDLE);
        step      = (state_q == HD_DRAIN);
        busy      = (state_q == HD_DRAIN);
    end

    // Next-state logic and the done condition.
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        case (state_q)
            HD_IDLE: begin
                if (load_take) begin
                    if (vec_zero) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = HD_DRAIN;
                    end
                end
            end
            HD_DRAIN: begin
                if (rest_zero) begin
                    state_d = HD_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = HD_IDLE;
        endcase
    end

    // Register the state and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HD_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
        end
    end
endmodule

// File: rtl/hit_drain.sv
`timescale 1ns/1ps
// Module: hit_drain (top)
// Drains a multi-hot vector one set bit per cycle, lowest index first,
// and issues each index as an address.
// Assumes at most MAX_HITS bits are set in any vector that is loaded.
module hit_drain #(
    parameter int VEC_W    = 32,
    parameter int MAX_HITS = 4,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [IDX_W-1:0] addr_o,
    output logic             addr_vld_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [VEC_W-1:0] work_q;
    logic [IDX_W-1:0] enc_idx;
    logic             enc_found;
    logic             load_take;
    logic             step;
    logic             rest_zero;

    hd_prio_enc #(.VEC_W(VEC_W)) u_enc (
        .vec   (work_q),
        .idx   (enc_idx),
        .found (enc_found)
    );

    hd_work_reg #(.VEC_W(VEC_W)) u_work (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_take (load_take),
        .vec_i     (vec_i),
        .step      (step),
        .sel_idx   (enc_idx),
        .work_q    (work_q),
        .rest_zero (rest_zero)
    );

    hd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .vec_zero  (vec_i == '0),
        .rest_zero (rest_zero),
        .load_take (load_take),
        .step      (step),
        .busy      (busy_o),
        .done      (done_o)
    );

    // Present the address only while a bit is being issued.
    always_comb begin
        addr_vld_o = enc_found;
        addr_o     = enc_found ? enc_idx : '0;
    end
endmodule

// File: rtl/hd_checker.sv
`timescale 1ns/1ps
// Module: hd_checker
// Property checks for hit_drain, attached to it with a bind.
// Assumes that vectors loaded while idle hold at most MAX_HITS set bits.
module hd_checker #(
    parameter int VEC_W    = 32,
    parameter int MAX_HITS = 4,
    localparam int IDX_W = $clog2(VEC_W),
    localparam int CNT_W = $clog2(MAX_HITS + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [VEC_W-1:0] vec_i,
    input logic [IDX_W-1:0] addr_o,
    input logic             addr_vld_o,
    input logic             busy_o,
    input logic             done_o
);
    logic [CNT_W-1:0] issued_q;

    // Count the addresses issued since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q <= '0;
        end else if (done_o) begin
            issued_q <= '0;
        end else if (addr_vld_o && issued_q != '1) begin
            issued_q <= issued_q + 1'b1;
        end
    end

    // R4: an accepted vector holds at most MAX_HITS set bits (input assumption).
    assert_input_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |-> ($countones(vec_i) <= MAX_HITS));

    // R4: a run never issues more than MAX_HITS addresses.
    assert_issue_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issued_q <= CNT_W'(MAX_HITS));

    // R3: consecutive addresses within a run rise strictly.
    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && $past(addr_vld_o)) |-> (addr_o > $past(addr_o)));

    // R5: busy and valid go together.
    assert_busy_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == addr_vld_o);

    // R6: done is never high while a run is in progress.
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: the end of a run is followed by a done pulse.
    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7: an empty vector finishes at once, without a run.
    assert_zero_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o && vec_i == '0) |=> (done_o && !busy_o));

    // R9: the address reads zero when no address is issued.
    assert_idle_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld_o |-> (addr_o == '0));
endmodule

bind hit_drain hd_checker #(.VEC_W(VEC_W), .MAX_HITS(MAX_HITS)) u_hd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .vec_i      (vec_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_hit_drain.sv
`timescale 1ns/1ps
module test_hit_drain;
    localparam int VW = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [VW-1:0] vec_i = '0;
    logic [IW-1:0] addr_o;
    logic          addr_vld_o;
    logic          busy_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hit_drain i_hit_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .vec_i      (vec_i),
        .addr_o     (addr_o),
        .addr_vld_o (addr_vld_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a load at the current falling edge; return at the next falling edge.
    task automatic start(input logic [VW-1:0] v);
        load_i = 1'b1;
        vec_i  = v;
        @(negedge clk);
        load_i = 1'b0;
        vec_i  = '0;
    endtask

    // Check a run. The call is made at the falling edge where the first
    // sample is due; the task returns at the falling edge of the done cycle.
    task automatic check_run(input logic [VW-1:0] v, input bit interfere);
        int pos[VW];
        int n = 0;
        for (int i = 0; i < VW; i++) begin
            if (v[i]) begin
                pos[n] = i;
                n++;
            end
        end
        for (int j = 0; j < n; j++) begin
            // R2, R3: the j-th lowest set position is issued, with valid high.
            chk(addr_vld_o === 1'b1, "R2 valid", int'(addr_vld_o), 1);
            chk(addr_o == IW'(pos[j]), "R3 address order", int'(addr_o), pos[j]);
            // R5: busy is high together with valid.
            chk(busy_o === 1'b1, "R5 busy during run", int'(busy_o), 1);
            chk(done_o === 1'b0, "R6 no done during run", int'(done_o), 0);
            if (interfere && j == 0) begin
                // R8: a strobe while busy must be ignored.
                load_i = 1'b1;
                vec_i  = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            load_i = 1'b0;
            vec_i  = '0;
        end
        // R4/R6: after exactly n addresses, done pulses and everything else is low.
        chk(done_o === 1'b1, "R6 done pulse", int'(done_o), 1);
        chk(addr_vld_o === 1'b0, "R4 address count", int'(addr_vld_o), 0);
        chk(busy_o === 1'b0, "R5 busy low at done", int'(busy_o), 0);
        chk(addr_o == '0, "R9 zero address when idle", int'(addr_o), 0);
    endtask

    // A full run followed by one idle cycle, checking that done falls.
    task automatic run(input logic [VW-1:0] v, input bit interfere);
        start(v);
        check_run(v, interfere);
        @(negedge clk);
        chk(done_o === 1'b0, "R6 single done pulse", int'(done_o), 0);
        // R8: a dropped strobe must not start a further run.
        chk(addr_vld_o === 1'b0, "R8 no extra run", int'(addr_vld_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state while reset is held and in the first cycle after it.
        repeat (3) @(negedge clk);
        chk(!busy_o && !addr_vld_o && !done_o && addr_o == '0, "R1 reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !addr_vld_o && !done_o && addr_o == '0, "R1 after reset", int'(done_o), 0);

        // R7: an empty vector gives done at once and no address.
        start('0);
        chk(done_o === 1'b1, "R7 empty done", int'(done_o), 1);
        chk(addr_vld_o === 1'b0, "R7 empty no valid", int'(addr_vld_o), 0);
        chk(busy_o === 1'b0, "R7 empty not busy", int'(busy_o), 0);
        @(negedge clk);
        chk(done_o === 1'b0, "R7 done drops", int'(done_o), 0);

        // R2: every single bit.
        for (int a = 0; a < VW; a++) run(VW'(1) << a, 1'b0);

        // R2, R3: every pair of bits.
        for (int a = 0; a < VW; a++)
            for (int b = a + 1; b < VW; b++)
                run((VW'(1) << a) | (VW'(1) << b), 1'b0);

        // R2, R4: evenly spaced triples and quads.
        for (int s = 1; s <= 10; s++)
            for (int a = 0; a + 3 * s < VW; a++) begin
                run((VW'(1) << a) | (VW'(1) << (a + s)) | (VW'(1) << (a + 2 * s)), 1'b0);
                run((VW'(1) << a) | (VW'(1) << (a + s)) | (VW'(1) << (a + 2 * s))
                    | (VW'(1) << (a + 3 * s)), 1'b0);
            end

        // R8: strobes during runs of one to four bits.
        run(32'h0000_0400, 1'b1);
        run(32'h8000_0001, 1'b1);
        run(32'h0800_5004, 1'b1);
        run(32'h4210_0000, 1'b1);

        // R10: back-to-back loads taken in the done cycle.
        start(32'h0000_00C0);
        check_run(32'h0000_00C0, 1'b0);
        start(32'h9000_0002);
        check_run(32'h9000_0002, 1'b0);
        start('0);
        // R10 with an empty vector: done stays high for a second cycle.
        chk(done_o === 1'b1, "R10 empty after done", int'(done_o), 1);
        start(32'h0001_0000);
        check_run(32'h0001_0000, 1'b0);
        @(negedge clk);
        chk(done_o === 1'b0, "R10 chain ends", int'(done_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule